// File: doc/BRIEF.md
# Banked UART Enhanced Register Decoder

This block is the host-facing register front end of a 16550-style serial port that keeps a set of extra configuration registers behind a magic line-control value. A byte-wide bus with a 3-bit offset, write data, and separate read and write strobes reaches it. Writing the magic value into the line-control register at offset 3 opens the enhanced view. In that view, offset 2 becomes the enhanced feature register, and offsets 4 to 7 reach one of four small banks. The bank is chosen by the two top bits of the enhanced feature register.

Bank 0 holds the four flow-control characters and bank 1 the four FIFO thresholds. Bank 2 holds an enumeration value, a read-only hardware identity, an extended control byte and a status byte. Bank 3 is empty. When line-control holds any other value, offsets 2 and 4 to 7 reach plain standard-register storage, and the bank contents stay as they were. Read data is combinational. The serial shifter, baud generator and FIFOs sit elsewhere. The enhanced-mode enable bit leaves the block on its own output.

Top module: `xur_regfile`

## Requirements
- R1: After reset every location reads 0x00, except the hardware identity (bank 2, offset 5), which reads the HW_ID parameter.
- R2: Offset 3 is the line-control register in every mode: a write stores the byte and a read returns it.
- R3: While line-control equals 0xBF, offset 2 reads and writes the enhanced feature register. Otherwise offset 2 reaches a separate standard byte.
- R4: In the enhanced view, enhanced feature bits 7:6 select the bank (0x00, 0x40, 0x80, 0xC0 give banks 0 to 3), and offsets 4, 5, 6, 7 reach slots 0 to 3 of that bank.
- R5: Banks 0 and 1 have four read/write byte slots each.
- R6: In bank 2, offset 5 returns HW_ID and ignores writes. Offsets 4, 6 and 7 are read/write bytes.
- R7: Bank 3 reads 0x00 at offsets 4 to 7 and ignores writes there.
- R8: While line-control differs from 0xBF, writes to offsets 2 and 4 to 7 go to standard storage and leave the enhanced feature register and all bank slots unchanged.
- R9: Output enh_en equals enhanced feature bit 4. It changes only through a write of that register, and is kept while line-control is changed.
- R10: rdata is 0x00 whenever rd_en is low. With rd_en high, it shows the addressed register in the same cycle.
- R11: Offsets 0 and 1 always reach standard storage, whatever line-control holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write byte |
| wr_en | input | 1 | Write strobe, takes effect at the clock edge |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read byte, combinational |
| enh_en | output | 1 | Enhanced-mode enable bit |

## Verification
The bench builds the block with HW_ID set to 0x02 rather than the default 0x01. This proves that the identity slot carries the parameter and not a fixed constant. All other parameters keep their defaults, so the magic value is 0xBF, the bank field sits at bits 7:6 and the enable bit at bit 4. With those settings the directed part can walk every bank at every offset and toggle line-control between the magic value and ordinary values. A long random phase then mixes mode switches, bank switches and writes to read-only slots.

// File: rtl/xur_pkg.sv
package xur_pkg;
   localparam int BANK_W = 2;
   localparam int SLOT_W = 2;
   localparam int NUM_BANKS = 1 << BANK_W;
   localparam int NUM_SLOTS = 1 << SLOT_W;

   typedef enum logic [1:0] {
      TGT_STD  = 2'd0,
      TGT_LCR  = 2'd1,
      TGT_EFR  = 2'd2,
      TGT_BANK = 2'd3
   } xur_tgt_e;

   typedef struct packed {
      xur_tgt_e          tgt;
      logic [BANK_W-1:0] bank;
      logic [SLOT_W-1:0] slot;
   } xur_route_t;
endpackage

// File: rtl/xur_decode.sv
module xur_decode
   import xur_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter int                ADDR_W    = 3,
   parameter logic [DATA_W-1:0] MAGIC     = 8'hBF,
   parameter int                LCR_OFS   = 3,
   parameter int                EFR_OFS   = 2,
   parameter int                BANK_BASE = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] lcr,
   input  logic [BANK_W-1:0] bank_fld,
   output xur_route_t        route
);
   logic              enh_view;
   logic [ADDR_W-1:0] rel_ofs;

   assign enh_view = (lcr == MAGIC);
   assign rel_ofs  = addr - ADDR_W'(BANK_BASE);

   always_comb begin
      route.tgt  = TGT_STD;
      route.bank = bank_fld;
      route.slot = rel_ofs[SLOT_W-1:0];
      if (addr == ADDR_W'(LCR_OFS)) begin
         route.tgt = TGT_LCR;
      end else if (enh_view && addr == ADDR_W'(EFR_OFS)) begin
         route.tgt = TGT_EFR;
      end else if (enh_view && addr >= ADDR_W'(BANK_BASE)) begin
         route.tgt = TGT_BANK;
      end
   end
endmodule

// File: rtl/xur_bank.sv
module xur_bank
   import xur_pkg::*;
#(
   parameter int                           DATA_W    = 8,
   parameter logic [NUM_SLOTS-1:0]         WR_MASK   = '1,
   parameter logic [NUM_SLOTS*DATA_W-1:0]  CONST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SLOT_W-1:0] slot,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] slot_val [NUM_SLOTS];

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      if (WR_MASK[s]) begin : g_rw
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (we && slot == SLOT_W'(s)) begin
               q <= wdata;
            end
         end
         assign slot_val[s] = q;
      end else begin : g_ro
         assign slot_val[s] = CONST_VAL[s*DATA_W +: DATA_W];
      end
   end

   assign rdata = slot_val[slot];
endmodule

// File: rtl/xur_regfile.sv
module xur_regfile
   import xur_pkg::*;
#(
   parameter int                   DATA_W       = 8,
   parameter int                   ADDR_W       = 3,
   parameter logic [DATA_W-1:0]    MAGIC        = 8'hBF,
   parameter logic [DATA_W-1:0]    HW_ID        = 8'h01,
   parameter int                   LCR_OFS      = 3,
   parameter int                   EFR_OFS      = 2,
   parameter int                   BANK_BASE    = 4,
   parameter int                   EN_BIT       = 4,
   parameter int                   ID_BANK      = 2,
   parameter int                   ID_SLOT      = 1,
   parameter logic [NUM_BANKS-1:0] BANK_PRESENT = 4'b0111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rdata,
   output logic              enh_en
);
   localparam int NUM_OFS = 1 << ADDR_W;
   localparam int FLD_LSB = DATA_W - BANK_W;

   if (DATA_W < 8) begin : g_bad_width
      $error("xur_regfile: DATA_W must be at least 8");
   end
   if (BANK_BASE + NUM_SLOTS > NUM_OFS) begin : g_bad_base
      $error("xur_regfile: bank window exceeds address space");
   end
   if (EN_BIT >= FLD_LSB) begin : g_bad_en
      $error("xur_regfile: enable bit overlaps bank field");
   end
   if (LCR_OFS == EFR_OFS || LCR_OFS >= BANK_BASE - 0 && LCR_OFS < BANK_BASE + NUM_SLOTS) begin : g_bad_ofs
      $error("xur_regfile: offset map overlaps");
   end

   logic [DATA_W-1:0] lcr_q;
   logic [DATA_W-1:0] efr_q;
   logic [DATA_W-1:0] std_q  [NUM_OFS];
   logic [DATA_W-1:0] bank_rd[NUM_BANKS];
   xur_route_t        route;

   xur_decode #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .MAGIC    (MAGIC),
      .LCR_OFS  (LCR_OFS),
      .EFR_OFS  (EFR_OFS),
      .BANK_BASE(BANK_BASE)
   ) u_decode (
      .addr    (addr),
      .lcr     (lcr_q),
      .bank_fld(efr_q[DATA_W-1:FLD_LSB]),
      .route   (route)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcr_q <= '0;
         efr_q <= '0;
      end else if (wr_en) begin
         if (route.tgt == TGT_LCR) lcr_q <= wdata;
         if (route.tgt == TGT_EFR) efr_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_OFS; i++) std_q[i] <= '0;
      end else if (wr_en && route.tgt == TGT_STD) begin
         std_q[addr] <= wdata;
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      if (BANK_PRESENT[b]) begin : g_on
         localparam logic [NUM_SLOTS-1:0] WMASK =
            (b == ID_BANK) ? ~(NUM_SLOTS'(1) << ID_SLOT) : '1;
         localparam logic [NUM_SLOTS*DATA_W-1:0] CVAL =
            (b == ID_BANK) ? ((NUM_SLOTS*DATA_W)'(HW_ID) << (ID_SLOT*DATA_W)) : '0;
         logic bank_we;
         assign bank_we = wr_en && route.tgt == TGT_BANK && route.bank == BANK_W'(b);
         xur_bank #(
            .DATA_W   (DATA_W),
            .WR_MASK  (WMASK),
            .CONST_VAL(CVAL)
         ) u_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (bank_we),
            .slot (route.slot),
            .wdata(wdata),
            .rdata(bank_rd[b])
         );
      end else begin : g_off
         assign bank_rd[b] = '0;
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (route.tgt)
            TGT_LCR:  rdata = lcr_q;
            TGT_EFR:  rdata = efr_q;
            TGT_BANK: rdata = bank_rd[route.bank];
            default:  rdata = std_q[addr];
         endcase
      end
   end

   assign enh_en = efr_q[EN_BIT];
endmodule

// File: rtl/xur_regfile_chk.sv
module xur_regfile_chk #(
   parameter int                DATA_W    = 8,
   parameter int                ADDR_W    = 3,
   parameter logic [DATA_W-1:0] MAGIC     = 8'hBF,
   parameter logic [DATA_W-1:0] HW_ID     = 8'h01,
   parameter int                LCR_OFS   = 3,
   parameter int                EFR_OFS   = 2,
   parameter int                BANK_BASE = 4,
   parameter int                ID_SLOT   = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] rdata,
   input logic              enh_en,
   input logic [DATA_W-1:0] lcr_q,
   input logic [DATA_W-1:0] efr_q
);
   logic       enh_view;
   logic [1:0] bank_fld;
   assign enh_view = (lcr_q == MAGIC);
   assign bank_fld = efr_q[DATA_W-1 -: 2];

   p_lcr_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(LCR_OFS)) |=> (lcr_q == $past(wdata)));

   p_lcr_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(LCR_OFS)) |-> (rdata == lcr_q));

   p_efr_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && enh_view && addr == ADDR_W'(EFR_OFS)) |-> (rdata == efr_q));

   p_hwid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && enh_view && bank_fld == 2'd2 && addr == ADDR_W'(BANK_BASE + ID_SLOT))
      |-> (rdata == HW_ID));

   p_bank3_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && enh_view && bank_fld == 2'd3 && addr >= ADDR_W'(BANK_BASE))
      |-> (rdata == '0));

   p_efr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!enh_view) |=> $stable(efr_q));

   p_enh_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && enh_view && addr == ADDR_W'(EFR_OFS)) |=> $stable(enh_en));

   p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en) |-> (rdata == '0));
endmodule

bind xur_regfile xur_regfile_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .MAGIC    (MAGIC),
   .HW_ID    (HW_ID),
   .LCR_OFS  (LCR_OFS),
   .EFR_OFS  (EFR_OFS),
   .BANK_BASE(BANK_BASE),
   .ID_SLOT  (ID_SLOT)
) u_chk (.*);

// File: tb/xur_regfile_tb.sv
`timescale 1ns/1ps
module xur_regfile_tb;
   localparam int HWID = 8'h02;
   localparam int MAGICV = 8'hBF;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rdata;
   logic       enh_en;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int std_m [8];
   int lcr_m;
   int efr_m;
   int bk_m [4][4];

   always #5 clk = ~clk;

   xur_regfile #(.HW_ID(8'(HWID))) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
      .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .enh_en(enh_en)
   );

   function automatic int exp_rd(int a);
      int b;
      if (a == 3) return lcr_m;
      if (lcr_m == MAGICV && a == 2) return efr_m;
      if (lcr_m == MAGICV && a >= 4) begin
         b = (efr_m >> 6) & 3;
         if (b == 3) return 0;
         if (b == 2 && a == 5) return HWID;
         return bk_m[b][a-4];
      end
      return std_m[a];
   endfunction

   function automatic string req_of(int a);
      int b;
      if (a == 3) return "R2";
      if (a < 2) return "R11";
      if (lcr_m != MAGICV) return "R8";
      if (a == 2) return "R3";
      b = (efr_m >> 6) & 3;
      if (b == 3) return "R7";
      if (b == 2) return "R6";
      return "R5";
   endfunction

   task automatic model_wr(int a, int d);
      int b;
      if (a == 3) lcr_m = d;
      else if (lcr_m == MAGICV && a == 2) efr_m = d;
      else if (lcr_m == MAGICV && a >= 4) begin
         b = (efr_m >> 6) & 3;
         if (b < 2 || (b == 2 && a != 5)) bk_m[b][a-4] = d;
      end else std_m[a] = d;
   endtask

   task automatic step(bit w, bit r, int a, int d, string tag);
      int exp_v;
      int exp_e;
      string rq;
      addr  = 3'(a);
      wdata = 8'(d);
      wr_en = w;
      rd_en = r;
      #1;
      exp_v = r ? exp_rd(a) : 0;
      exp_e = (efr_m >> 4) & 1;
      rq = (tag != "") ? tag : (r ? req_of(a) : "R10");
      checks++;
      if (rdata !== 8'(exp_v)) begin
         fails++;
         $display("FAIL %s rdata addr=%0d actual=%02h expected=%02h", rq, a, rdata, exp_v);
      end
      checks++;
      if (enh_en !== exp_e[0]) begin
         fails++;
         $display("FAIL R9 enh_en actual=%0b expected=%0b", enh_en, exp_e[0]);
      end
      @(posedge clk);
      if (w) model_wr(a, d);
      @(negedge clk);
      wr_en = 1'b0;
      rd_en = 1'b0;
   endtask

   task automatic rd(int a, string tag);
      step(1'b0, 1'b1, a, 0, tag);
   endtask

   task automatic wr(int a, int d);
      step(1'b1, 1'b0, a, d, "");
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      lcr_m = 0;
      efr_m = 0;
      foreach (std_m[i]) std_m[i] = 0;
      foreach (bk_m[i, j]) bk_m[i][j] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values in both views
      for (int a = 0; a < 8; a++) rd(a, "R1");
      wr(3, MAGICV);
      rd(2, "R1");
      for (int b = 0; b < 4; b++) begin
         wr(2, b << 6);
         for (int a = 4; a < 8; a++) rd(a, "R1");
      end

      // R8: plain view writes reach standard storage only
      wr(3, 8'h03);
      rd(3, "R2");
      for (int a = 0; a < 8; a++) if (a != 3) wr(a, 8'h50 + a);
      for (int a = 0; a < 8; a++) rd(a, "");
      wr(3, MAGICV);
      wr(2, 8'h00);
      for (int a = 4; a < 8; a++) rd(a, "R8");

      // R4/R5/R6/R7: fill every bank through the selected view
      for (int b = 0; b < 4; b++) begin
         wr(2, b << 6);
         for (int a = 4; a < 8; a++) wr(a, 8'h10 * (b + 1) + a);
         for (int a = 4; a < 8; a++) rd(a, "");
      end
      // R9: enable bit, kept across mode changes
      wr(2, 8'h50);
      rd(2, "R9");
      wr(3, 8'h1B);
      for (int a = 0; a < 8; a++) rd(a, "");
      wr(2, 8'h00);
      wr(3, MAGICV);
      rd(2, "R9");
      for (int b = 0; b < 4; b++) begin
         wr(2, (b << 6) | 8'h10);
         for (int a = 4; a < 8; a++) rd(a, "R4");
      end
      // R11: low offsets unaffected by view
      wr(0, 8'hA5);
      wr(1, 8'h5A);
      rd(0, "R11");
      rd(1, "R11");
      wr(3, 8'h00);
      rd(0, "R11");
      rd(1, "R11");
      // R10: no read strobe gives zero
      step(1'b0, 1'b0, 3, 0, "R10");

      // mixed random traffic
      for (int n = 0; n < 4000; n++) begin
         int a;
         int d;
         a = $urandom_range(0, 7);
         d = $urandom_range(0, 255);
         if (a == 3 && ($urandom_range(0, 1) == 1)) d = MAGICV;
         step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, d, "");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule